// File: doc/BRIEF.md
# Event Time-Surface Generator

This block turns a stream of address events into local decayed-timestamp contexts. Each event names a pixel (x,y), a polarity (ON or OFF) and a timestamp. The block keeps, for every pixel and each polarity, the time of the most recent event. On each accepted event it first records the new time. It then walks a square window of run-time radius r centred on the event and emits one decayed value per window position.

A pixel seen recently scores close to one, and one that has stayed quiet scores close to zero. The score falls off linearly with elapsed time over a window of length tau. Tau is a power of two chosen at run time, so the decay needs no divider. Values are unsigned fixed point with INT_W integer and FRAC_W fraction bits (Q8.8 by default; Q16.16 or Q32.32 by parameter).

A downstream stage, such as a prototype matcher, consumes the stream sample by sample. It uses the first and last markers to frame each surface.

Top module: `tsurf_gen`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0. Reset forgets every stored timestamp.
- R2: An event is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle on. It returns to 1 on the cycle after the last sample of that surface and not before.
- R3: Each event yields exactly (2r+1)² samples on consecutive cycles. `out_first` is 1 only on the first sample and `out_last` only on the final one.
- R4: Samples come in row-major order. The row offset runs from −r to +r as the outer loop and the column offset from −r to +r as the inner loop.
- R5: The centre sample always equals 1.0, which is the code 1<<FRAC_W (256 by default).
- R6: With dt = (t_event − t_stored) mod 2^TS_W and k = `cfg_tau_log2`, a neighbour inside the array gives 1<<FRAC_W − floor(dt·2^FRAC_W / 2^k) when dt < 2^k, and 0 otherwise.
- R7: A pixel/polarity never written since reset gives 0.
- R8: A window position outside the W_PIX×H_PIX array gives 0 and causes no memory read.
- R9: The surface reads only the stored times of the event's own polarity (`in_pol` 1 = ON, 0 = OFF). The other polarity's times have no effect.
- R10: A newer event at a pixel/polarity replaces the older stored time.
- R11: Radius and tau are taken at the accepting edge. Changes to `cfg_radius` or `cfg_tau_log2` during a surface do not affect it. A radius of 0 gives a single sample.
- R12: The first sample appears after the second rising edge that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Event present |
| in_ready | output | 1 | Block can take an event |
| in_x | input | $clog2(W_PIX) | Event column |
| in_y | input | $clog2(H_PIX) | Event row |
| in_pol | input | 1 | Polarity, 1 = ON, 0 = OFF |
| in_ts | input | TS_W | Event timestamp |
| cfg_radius | input | RAD_W | Window radius r |
| cfg_tau_log2 | input | $clog2(TS_W) | Decay window is 2^k time units |
| out_valid | output | 1 | Sample valid |
| out_first | output | 1 | First sample of a surface |
| out_last | output | 1 | Final sample of a surface |
| out_value | output | INT_W+FRAC_W | Decayed value, unsigned fixed point |

## Verification
A corrupted window counter shows up at the ports within a single surface. The sample count changes, the first/last markers move, or values land in the wrong row-major slot. A wrong memory address or a wrong polarity bit appears as a value that differs from the arithmetic model on a neighbour written at a known time. This is seen on the next event whose window covers that pixel. Faults in the decay path affect every non-centre sample of the next surface, and a bad handshake is seen on the cycle after the accepting edge or on the cycle after the last sample.

// File: rtl/tsurf_pkg.sv
package tsurf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } tsurf_state_e;

    function automatic logic in_span(input int c, input int lim);
        return (c >= 0) && (c < lim);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tsurf_store.sv
module tsurf_store #(
    parameter int W_PIX = 8,
    parameter int H_PIX = 8,
    parameter int TS_W  = 16,
    localparam int DEPTH = 2 * W_PIX * H_PIX,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [TS_W-1:0] wr_ts,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [TS_W-1:0] rd_ts,
    output logic            rd_hit
);

    logic [TS_W-1:0] stamp_mem [DEPTH];
    logic [DEPTH-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            stamp_mem[wr_addr] <= wr_ts;
        end
        if (rd_en) begin
            rd_ts <= stamp_mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            rd_hit <= 1'b0;
        end else begin
            if (wr_en) begin
                seen_q[wr_addr] <= 1'b1;
            end
            rd_hit <= rd_en && seen_q[rd_addr];
        end
    end

    // R10: writes happen only between surfaces, never while the window is read
    p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));

    // R7: a hit can only follow a read issued on the previous cycle
    p_hit_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> $past(rd_en));

endmodule

// File: rtl/tsurf_scan.sv
module tsurf_scan
    import tsurf_pkg::*;
#(
    parameter int W_PIX = 8,
    parameter int H_PIX = 8,
    parameter int RAD_W = 2,
    localparam int XB = $clog2(W_PIX),
    localparam int YB = $clog2(H_PIX),
    localparam int OW = RAD_W + 1,
    localparam int CW = max3(XB, YB, RAD_W) + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [RAD_W-1:0] radius,
    input  logic [XB-1:0]    cx,
    input  logic [YB-1:0]    cy,
    output logic             busy,
    output logic             tap_first,
    output logic             tap_last,
    output logic             tap_inside,
    output logic [XB-1:0]    tap_x,
    output logic [YB-1:0]    tap_y
);

    logic signed [OW-1:0] ox, oy, rpos;
    logic [RAD_W-1:0]     rad_q;
    logic signed [CW-1:0] nx, ny;

    assign rpos = $signed({1'b0, rad_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            rad_q <= '0;
            ox    <= '0;
            oy    <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            rad_q <= radius;
            ox    <= -$signed({1'b0, radius});
            oy    <= -$signed({1'b0, radius});
        end else if (busy) begin
            if (ox == rpos) begin
                ox <= -rpos;
                if (oy == rpos) begin
                    busy <= 1'b0;
                end else begin
                    oy <= oy + OW'(1);
                end
            end else begin
                ox <= ox + OW'(1);
            end
        end
    end

    assign nx = CW'(ox) + $signed(CW'({1'b0, cx}));
    assign ny = CW'(oy) + $signed(CW'({1'b0, cy}));

    always_comb begin
        tap_first  = busy && (ox == -rpos) && (oy == -rpos);
        tap_last   = busy && (ox == rpos) && (oy == rpos);
        tap_inside = busy && in_span(int'(nx), W_PIX) && in_span(int'(ny), H_PIX);
        tap_x      = XB'(nx);
        tap_y      = YB'(ny);
    end

    // R4: offsets stay inside the square window while scanning
    p_offset_window_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ox >= -rpos) && (ox <= rpos) && (oy >= -rpos) && (oy <= rpos));

    // R3: the scan ends right after the final window position
    p_last_stops_r3: assert property (@(posedge clk) disable iff (rst)
        tap_last |=> !busy);

    // R4: a new scan always begins at the top-left corner of the window
    p_start_corner_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> tap_first);

endmodule

// File: rtl/tsurf_decay.sv
module tsurf_decay #(
    parameter int TS_W   = 16,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    localparam int OUT_W = INT_W + FRAC_W,
    localparam int TAU_W = $clog2(TS_W),
    localparam int SW    = TS_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    input  logic             s_inside,
    input  logic             s_hit,
    input  logic             s_first,
    input  logic             s_last,
    input  logic [TS_W-1:0]  s_stamp,
    input  logic [TS_W-1:0]  now,
    input  logic [TAU_W-1:0] tau_log2,
    output logic             out_valid,
    output logic             out_first,
    output logic             out_last,
    output logic [OUT_W-1:0] out_value
);

    localparam logic [OUT_W-1:0] ONE = OUT_W'(1) << FRAC_W;

    logic [TS_W-1:0]  dt;
    logic [TS_W:0]    span;
    logic [SW-1:0]    scaled;
    logic             live;
    logic [OUT_W-1:0] value_c;

    always_comb begin
        dt      = now - s_stamp;
        span    = (TS_W + 1)'(1) << tau_log2;
        live    = s_inside && s_hit && ({1'b0, dt} < span);
        scaled  = {dt, {FRAC_W{1'b0}}} >> tau_log2;
        value_c = live ? (ONE - OUT_W'(scaled)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= s_valid;
            out_first <= s_valid && s_first;
            out_last  <= s_valid && s_last;
            out_value <= s_valid ? value_c : '0;
        end
    end

    // R6: a decayed value never exceeds 1.0
    p_value_cap_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_value <= ONE));

    // R8: positions outside the array produce a zero sample
    p_outside_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_inside) |=> (out_valid && (out_value == '0)));

    // R3: markers appear only on valid samples
    p_marker_valid_r3: assert property (@(posedge clk) disable iff (rst)
        (out_first || out_last) |-> out_valid);

endmodule

// File: rtl/tsurf_gen.sv
module tsurf_gen
    import tsurf_pkg::*;
#(
    parameter int W_PIX  = 8,
    parameter int H_PIX  = 8,
    parameter int TS_W   = 16,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    parameter int RAD_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [$clog2(W_PIX)-1:0]    in_x,
    input  logic [$clog2(H_PIX)-1:0]    in_y,
    input  logic                        in_pol,
    input  logic [TS_W-1:0]             in_ts,
    input  logic [RAD_W-1:0]            cfg_radius,
    input  logic [$clog2(TS_W)-1:0]     cfg_tau_log2,
    output logic                        out_valid,
    output logic                        out_first,
    output logic                        out_last,
    output logic [INT_W+FRAC_W-1:0]     out_value
);

    localparam int XB    = $clog2(W_PIX);
    localparam int YB    = $clog2(H_PIX);
    localparam int TAU_W = $clog2(TS_W);
    localparam int DEPTH = 2 * W_PIX * H_PIX;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic [XB-1:0]    x;
        logic [YB-1:0]    y;
        logic             pol;
        logic [TS_W-1:0]  ts;
        logic [TAU_W-1:0] tau;
    } event_t;

    function automatic logic [AW-1:0] addr_of(input logic p, input logic [YB-1:0] y,
                                              input logic [XB-1:0] x);
        return AW'(p) * AW'(W_PIX * H_PIX) + AW'(y) * AW'(W_PIX) + AW'(x);
    endfunction

    tsurf_state_e state;
    event_t       ev_q;
    logic         accept;

    logic          busy, tap_first, tap_last, tap_inside;
    logic [XB-1:0] tap_x;
    logic [YB-1:0] tap_y;

    logic            rd_en, rd_hit;
    logic [AW-1:0]   rd_addr;
    logic [TS_W-1:0] rd_ts;

    logic s1_valid, s1_inside, s1_first, s1_last;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (accept) state <= ST_SCAN;
                ST_SCAN:  if (tap_last) state <= ST_DRAIN;
                ST_DRAIN: if (out_valid && out_last) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            ev_q <= '{x: in_x, y: in_y, pol: in_pol, ts: in_ts, tau: cfg_tau_log2};
        end
    end

    tsurf_scan #(.W_PIX(W_PIX), .H_PIX(H_PIX), .RAD_W(RAD_W)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .radius     (cfg_radius),
        .cx         (ev_q.x),
        .cy         (ev_q.y),
        .busy       (busy),
        .tap_first  (tap_first),
        .tap_last   (tap_last),
        .tap_inside (tap_inside),
        .tap_x      (tap_x),
        .tap_y      (tap_y)
    );

    assign rd_en   = tap_inside;
    assign rd_addr = addr_of(ev_q.pol, tap_y, tap_x);

    tsurf_store #(.W_PIX(W_PIX), .H_PIX(H_PIX), .TS_W(TS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_addr (addr_of(in_pol, in_y, in_x)),
        .wr_ts   (in_ts),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_ts   (rd_ts),
        .rd_hit  (rd_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_inside <= 1'b0;
            s1_first  <= 1'b0;
            s1_last   <= 1'b0;
        end else begin
            s1_valid  <= busy;
            s1_inside <= tap_inside;
            s1_first  <= tap_first;
            s1_last   <= tap_last;
        end
    end

    tsurf_decay #(.TS_W(TS_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_decay (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (s1_valid),
        .s_inside  (s1_inside),
        .s_hit     (rd_hit),
        .s_first   (s1_first),
        .s_last    (s1_last),
        .s_stamp   (rd_ts),
        .now       (ev_q.ts),
        .tau_log2  (ev_q.tau),
        .out_valid (out_valid),
        .out_first (out_first),
        .out_last  (out_last),
        .out_value (out_value)
    );

    // R2: taking an event closes the input until the surface is out
    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    // R2: no sample is emitted while the input is open
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid);

    // R12: the scan starts on the cycle right after the accepting edge
    p_scan_follows_r12: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

endmodule

// File: tb/sim_tsurf_gen.sv
module sim_tsurf_gen;

    localparam int W   = 8;
    localparam int H   = 8;
    localparam int ONE = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_x;
    logic [2:0]  in_y;
    logic        in_pol;
    logic [15:0] in_ts;
    logic [1:0]  cfg_radius;
    logic [3:0]  cfg_tau_log2;
    logic        out_valid;
    logic        out_first;
    logic        out_last;
    logic [15:0] out_value;

    always #2 clk = ~clk;

    tsurf_gen u0 (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_x         (in_x),
        .in_y         (in_y),
        .in_pol       (in_pol),
        .in_ts        (in_ts),
        .cfg_radius   (cfg_radius),
        .cfg_tau_log2 (cfg_tau_log2),
        .out_valid    (out_valid),
        .out_first    (out_first),
        .out_last     (out_last),
        .out_value    (out_value)
    );

    int checks = 0;
    int fails  = 0;
    int tnow   = 100;
    int mstamp [2][8][8];
    bit mseen  [2][8][8];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_val(input int x, input int y, input int p,
                                     input int t, input int k);
        int dt;
        if (x < 0 || x >= W || y < 0 || y >= H) return 0;
        if (!mseen[p][y][x]) return 0;
        dt = (t - mstamp[p][y][x]) & 16'hFFFF;
        if (dt >= (1 << k)) return 0;
        return ONE - ((dt * ONE) >> k);
    endfunction

    task automatic run_event(input int x, input int y, input int p, input int t,
                             input int r, input int k, input string tag);
        int n;
        int idx;
        int e;
        string vt;
        while (!in_ready) @(negedge clk);
        in_valid     = 1'b1;
        in_x         = 3'(x);
        in_y         = 3'(y);
        in_pol       = p[0];
        in_ts        = 16'(t);
        cfg_radius   = 2'(r);
        cfg_tau_log2 = 4'(k);
        mstamp[p][y][x] = t & 16'hFFFF;
        mseen[p][y][x]  = 1'b1;
        @(negedge clk);
        in_valid     = 1'b0;
        cfg_radius   = 2'(3 - r);          // R11: disturb settings mid-surface
        cfg_tau_log2 = 4'(15 - k);
        chk(!in_ready, "R2 ready drops after accept", int'(in_ready), 0);
        chk(!out_valid, "R12 no sample one edge after accept", int'(out_valid), 0);
        @(negedge clk);
        chk(!out_valid, "R12 no sample two edges after accept", int'(out_valid), 0);
        n   = 2 * r + 1;
        idx = 0;
        for (int dy = -r; dy <= r; dy++) begin
            for (int dx = -r; dx <= r; dx++) begin
                @(negedge clk);
                chk(out_valid, "R3 consecutive valid samples", int'(out_valid), 1);
                chk(out_first == (idx == 0), "R3 first marker", int'(out_first),
                    int'(idx == 0));
                chk(out_last == (idx == n * n - 1), "R3 last marker", int'(out_last),
                    int'(idx == n * n - 1));
                e = model_val(x + dx, y + dy, p, t, k);
                if (x + dx < 0 || x + dx >= W || y + dy < 0 || y + dy >= H)
                    vt = "R8 outside array";
                else if (dx == 0 && dy == 0)
                    vt = "R5 centre";
                else if (!mseen[p][y + dy][x + dx])
                    vt = "R7 unwritten";
                else
                    vt = tag;
                chk(int'(out_value) == e, $sformatf("%s R4 slot %0d", vt, idx),
                    int'(out_value), e);
                idx++;
            end
        end
        @(negedge clk);
        chk(!out_valid, "R3 no extra sample", int'(out_valid), 0);
        chk(in_ready, "R2 ready returns after last", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++)
            for (int y = 0; y < H; y++)
                for (int x = 0; x < W; x++) begin
                    mseen[p][y][x]  = 1'b0;
                    mstamp[p][y][x] = 0;
                end
        rst          = 1'b1;
        in_valid     = 1'b0;
        in_x         = '0;
        in_y         = '0;
        in_pol       = 1'b0;
        in_ts        = '0;
        cfg_radius   = '0;
        cfg_tau_log2 = '0;
        repeat (3) @(negedge clk);
        chk(in_ready, "R1 ready during reset", int'(in_ready), 1);
        chk(!out_valid, "R1 no output during reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready, "R1 ready after reset", int'(in_ready), 1);
        chk(!out_valid, "R1 idle output after reset", int'(out_valid), 0);

        // R7 / R8: fresh memory, corner event with the widest window
        run_event(0, 0, 1, tnow, 3, 4, "R7 fresh memory");

        // R6 / R9: sweep every pixel, polarity alternating
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                tnow += 3;
                run_event(x, y, (x + y) & 1, tnow, 2, 5, "R6 sweep decay");
            end

        // R11: every radius, including 0, and a far corner
        for (int r = 0; r < 4; r++) begin
            tnow += 1;
            run_event(3, 3, 0, tnow, r, 6, "R11 radius");
        end
        tnow += 1;
        run_event(7, 7, 1, tnow, 3, 7, "R8 far corner");

        // R6: every tau from a single tick upward
        for (int k = 0; k < 12; k++) begin
            tnow += 2;
            run_event(2, 5, 1, tnow, 1, k, "R6 tau sweep");
        end

        // R10: newer stamp replaces the older one
        tnow += 5;
        run_event(5, 1, 1, tnow, 0, 6, "R10 first write");
        tnow += 20;
        run_event(5, 1, 1, tnow, 0, 6, "R10 second write");
        tnow += 1;
        run_event(5, 2, 1, tnow, 1, 6, "R10 overwrite seen");

        // R9: an ON neighbour must not leak into an OFF surface
        tnow += 1;
        run_event(6, 2, 1, tnow, 0, 8, "R9 on write");
        tnow += 1;
        run_event(6, 3, 0, tnow, 1, 8, "R9 polarity");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule